// File: doc/BRIEF.md
# Carry-Flag Boolean Bit Processor

This block carries out single-bit Boolean operations in which the carry flag acts as a one-bit accumulator. It receives an operation that has already been decoded. The operation carries an operation code, an operand space, an address and a bit index. The block fetches the operand byte, picks out one bit, and then does one of two things. It either loads that bit into carry or combines it with carry by AND, OR or XOR. Otherwise it writes carry back into the selected bit through a read-modify-write of the whole byte.

The operand byte can come from five places. Two of them are held by the host core: the accumulator and the status word, which are sampled on the start cycle. The other three are reached over a simple request bus: short-direct RAM, the special-function register file, and memory addressed indirectly through the HL pair. The host core applies the results through write-enabled result ports when the done pulse arrives. Each operation takes a fixed number of clocks, which depends on the operand space and on whether the address lies in the fast internal RAM window. HL-indirect accesses outside that window can also be stretched by external wait cycles.

Top module: `cy_bitproc`

## Requirements
- R1: Operation code 0 loads the selected operand bit into carry. Carry is bit 0 of the status word, and bit index 0 selects the least significant bit of the operand byte. Operation codes are 0 load, 1 store, 2 AND, 3 OR, 4 XOR.
- R2: Codes 2, 3 and 4 replace carry with carry AND bit, carry OR bit and carry XOR bit. They leave every other status bit as sampled.
- R3: Code 1 (store) writes carry into the selected bit and leaves carry unchanged. Only a store asserts `mem_we`. A store into a bus space or into the accumulator does not raise `psw_we`.
- R4: A store reads the whole target byte and writes it back with only the indexed bit replaced. The other seven bits are unchanged.
- R5: A store into the status word (space 1) returns the modified byte as the new status word. This can change the zero flag (bit 6), the auxiliary carry (bit 4) or carry.
- R6: Space codes are 0 accumulator, 1 status word, 2 short-direct, 3 SFR and 4 HL-indirect. Every accumulator-space operation takes 4 clocks. `done` is high only in the last counted clock, and `busy` is low in the clock after it.
- R7: SFR-space and status-word-space operations take 7 clocks for load, AND, OR and XOR, and 8 clocks for a store.
- R8: A short-direct operation takes 6 clocks when the address lies in the fast window (default 0xFE20 to 0xFEFF). Outside the window it takes 7 clocks, or 8 clocks for a store.
- R9: An HL-indirect operation takes 6 clocks in the fast window. Outside it, a read operation takes 7+n clocks and a store takes 8+n+m clocks, where n and m are the clocks `mem_wait` is high during the read and the write access.
- R10: `start` is ignored while `busy` is high. It is also ignored when the operation code or the space code is above 4.
- R11: Accumulator-space and status-word-space operations make no bus request. SFR-space accesses assert `mem_sfr`, while short-direct and HL-indirect accesses do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| space | input | 3 | Operand space code |
| addr | input | 16 | Operand address for the bus spaces (HL value for indirect) |
| bit_idx | input | 3 | Selected bit, 0 = LSB |
| acc_i | input | 8 | Accumulator value, sampled at start |
| psw_i | input | 8 | Status word value, sampled at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final clock of the operation |
| acc_we | output | 1 | Accumulator result valid (with done) |
| acc_o | output | 8 | New accumulator value |
| psw_we | output | 1 | Status word result valid (with done) |
| psw_o | output | 8 | New status word value |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus access is a write |
| mem_sfr | output | 1 | Bus access targets the SFR file |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid in a request clock without wait |
| mem_wait | input | 1 | Stretches the current external access by one clock |

## Verification
The clock after the edge that accepts `start` is counted as clock 1. The result ports and `done` are therefore due in clock 4, 6, 7 or 8, plus the injected read and write waits for slow HL-indirect accesses. A store's written byte shows up in the bench memory one edge after `done`. The monitor notes the start clock and counts falling edges until `done`, comparing that count with the value the driver derived from the space, window and wait counts it applied. It samples the result ports and request lines on the falling edge where `done` is seen and checks memory one falling edge later. Any `done` with no pending item is a failure.

// File: rtl/cybp_pkg.sv
package cybp_pkg;

  typedef enum logic [2:0] {
    OP_LDC = 3'd0,
    OP_STC = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } bop_e;

  typedef enum logic [2:0] {
    SP_ACC   = 3'd0,
    SP_PSW   = 3'd1,
    SP_SHORT = 3'd2,
    SP_SFR   = 3'd3,
    SP_IND   = 3'd4
  } bsp_e;

  localparam int CY_POS = 0;
  localparam int CNT_W  = 4;

  // Clock count with no wait cycles (R6, R7, R8, R9)
  function automatic logic [CNT_W-1:0] base_cycles(input bop_e op, input bsp_e sp,
                                                   input logic fast);
    logic store;
    store = (op == OP_STC);
    case (sp)
      SP_ACC:         return CNT_W'(4);
      SP_PSW, SP_SFR: return store ? CNT_W'(8) : CNT_W'(7);
      default:        return fast ? CNT_W'(6) : (store ? CNT_W'(8) : CNT_W'(7));
    endcase
  endfunction

endpackage

// File: rtl/cybp_region.sv
module cybp_region #(
  parameter int            AW = 16,
  parameter logic [AW-1:0] LO = 16'hFE20,
  parameter logic [AW-1:0] HI = 16'hFEFF
) (
  input  logic [AW-1:0] addr_i,
  output logic          fast_o
);
  assign fast_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/cybp_bitop.sv
module cybp_bitop
  import cybp_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = $clog2(DW)
) (
  input  bop_e          op_i,
  input  logic [DW-1:0] byte_i,
  input  logic [BW-1:0] idx_i,
  input  logic          cy_i,
  output logic          cy_o,
  output logic [DW-1:0] byte_o
);
  logic sel;

  always_comb begin
    sel    = byte_i[idx_i];
    cy_o   = cy_i;
    byte_o = byte_i;
    case (op_i)
      OP_LDC:  cy_o = sel;
      OP_AND:  cy_o = cy_i & sel;
      OP_OR:   cy_o = cy_i | sel;
      OP_XOR:  cy_o = cy_i ^ sel;
      OP_STC:  byte_o[idx_i] = cy_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/cybp_seq.sv
module cybp_seq #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [CW-1:0] base_i,
  input  logic          hold,
  output logic          busy,
  output logic [CW-1:0] slot,
  output logic          last
);
  logic [CW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      slot   <= '0;
      base_q <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      slot   <= CW'(1);
      base_q <= base_i;
    end else if (busy && !hold) begin
      if (slot == base_q) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + CW'(1);
      end
    end
  end

  assign last = busy && (slot == base_q);

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (slot >= CW'(1)) && (slot <= base_q)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (last && !hold) |=> !busy); // R6
endmodule

// File: rtl/cy_bitproc.sv
module cy_bitproc
  import cybp_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            DW      = 8,
  parameter logic [AW-1:0] FAST_LO = 16'hFE20,
  parameter logic [AW-1:0] FAST_HI = 16'hFEFF,
  parameter int            BW      = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [2:0]    space,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bit_idx,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] psw_i,
  output logic          busy,
  output logic          done,
  output logic          acc_we,
  output logic [DW-1:0] acc_o,
  output logic          psw_we,
  output logic [DW-1:0] psw_o,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_sfr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_wait
);
  bop_e             op_q;
  bsp_e             sp_q;
  logic [AW-1:0]    addr_q;
  logic [BW-1:0]    idx_q;
  logic [DW-1:0]    psw_q;
  logic [DW-1:0]    byte_q;
  logic             fast_q;
  logic             fast_in;
  logic             cmd_ok;
  logic             launch;
  logic [CNT_W-1:0] base_in;
  logic [CNT_W-1:0] slot;
  logic             last;
  logic             hold;
  logic             rd_slot;
  logic             is_mem;
  logic             is_stc;
  logic             cy_new;
  logic [DW-1:0]    byte_new;
  logic [DW-1:0]    psw_mod;

  // Fast-window decode on the incoming address
  cybp_region #(.AW(AW), .LO(FAST_LO), .HI(FAST_HI)) u_region (
    .addr_i (addr),
    .fast_o (fast_in)
  );

  assign cmd_ok  = (op <= 3'd4) && (space <= 3'd4);
  assign launch  = start && !busy && cmd_ok;
  assign base_in = base_cycles(bop_e'(op), bsp_e'(space), fast_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_LDC;
      sp_q   <= SP_ACC;
      addr_q <= '0;
      idx_q  <= '0;
      psw_q  <= '0;
      byte_q <= '0;
      fast_q <= 1'b0;
    end else if (launch) begin
      op_q   <= bop_e'(op);
      sp_q   <= bsp_e'(space);
      addr_q <= addr;
      idx_q  <= bit_idx;
      psw_q  <= psw_i;
      fast_q <= fast_in;
      byte_q <= (bsp_e'(space) == SP_ACC) ? acc_i : psw_i;
    end else if (busy && rd_slot && is_mem && !hold) begin
      byte_q <= mem_rdata;
    end
  end

  assign is_mem  = (sp_q == SP_SHORT) || (sp_q == SP_SFR) || (sp_q == SP_IND);
  assign is_stc  = (op_q == OP_STC);
  assign rd_slot = (slot == CNT_W'(1));

  // External waits stretch only slow HL-indirect bus slots
  assign hold = busy && (sp_q == SP_IND) && !fast_q && mem_wait &&
                (rd_slot || (is_stc && last));

  cybp_seq #(.CW(CNT_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .base_i (base_in),
    .hold   (hold),
    .busy   (busy),
    .slot   (slot),
    .last   (last)
  );

  cybp_bitop #(.DW(DW), .BW(BW)) u_bitop (
    .op_i   (op_q),
    .byte_i (byte_q),
    .idx_i  (idx_q),
    .cy_i   (psw_q[CY_POS]),
    .cy_o   (cy_new),
    .byte_o (byte_new)
  );

  always_comb begin
    psw_mod         = psw_q;
    psw_mod[CY_POS] = cy_new;
  end

  assign done      = last && !hold;
  assign mem_req   = busy && is_mem && (rd_slot || (is_stc && last));
  assign mem_we    = busy && is_mem && is_stc && last;
  assign mem_sfr   = (sp_q == SP_SFR);
  assign mem_addr  = addr_q;
  assign mem_wdata = byte_new;
  assign acc_we    = done && is_stc && (sp_q == SP_ACC);
  assign acc_o     = byte_new;
  assign psw_we    = done && (!is_stc || (sp_q == SP_PSW));
  assign psw_o     = is_stc ? byte_new : psw_mod;

  AST_WR_ONLY_STC: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (op_q == OP_STC)); // R3
  AST_RMW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (((mem_wdata ^ byte_q) & ~(DW'(1) << idx_q)) == '0)); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q) && $stable(sp_q))); // R10
  AST_NO_BUS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (busy && ((sp_q == SP_ACC) || (sp_q == SP_PSW))) |-> !mem_req); // R11
endmodule

// File: tb/cy_bitproc_bench.sv
`timescale 1ns/1ps
module cy_bitproc_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op, space, bit_idx;
  logic [15:0] addr;
  logic [7:0]  acc_i, psw_i;
  logic        busy, done, acc_we, psw_we, mem_req, mem_we, mem_sfr, mem_wait;
  logic [7:0]  acc_o, psw_o, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  always #2.5 clk = ~clk;

  cy_bitproc u_cy_bitproc (
    .clk(clk), .rst(rst), .start(start), .op(op), .space(space), .addr(addr),
    .bit_idx(bit_idx), .acc_i(acc_i), .psw_i(psw_i), .busy(busy), .done(done),
    .acc_we(acc_we), .acc_o(acc_o), .psw_we(psw_we), .psw_o(psw_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sfr(mem_sfr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
  );

  logic [7:0] ram   [256];
  logic [7:0] sfr_m [256];
  assign mem_rdata = mem_sfr ? sfr_m[mem_addr[7:0]] : ram[mem_addr[7:0]];

  always @(posedge clk)
    if (mem_req && mem_we && !mem_wait) begin
      if (mem_sfr) sfr_m[mem_addr[7:0]] <= mem_wdata;
      else         ram[mem_addr[7:0]]   <= mem_wdata;
    end

  int rd_left = 0, wr_left = 0;
  always @(posedge clk) begin
    #1;
    mem_wait = 1'b0;
    if (mem_req && !mem_we && rd_left > 0) begin mem_wait = 1'b1; rd_left--; end
    else if (mem_req && mem_we && wr_left > 0) begin mem_wait = 1'b1; wr_left--; end
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    string      req;
    int         cyc;
    bit         acc_we;
    logic [7:0] acc;
    bit         psw_we;
    logic [7:0] psw;
    bit         chk_mem;
    bit         in_sfr;
    logic [7:0] midx;
    logic [7:0] mval;
    bit         no_bus;
  } item_t;
  item_t q[$];

  function automatic bit in_fast(input logic [15:0] a);
    return (a >= 16'hFE20) && (a <= 16'hFEFF);
  endfunction

  // Clock counts taken from R6..R9
  function automatic int exp_cycles(input int o, input int s, input logic [15:0] a,
                                    input int n, input int m);
    bit st = (o == 1);
    if (s == 0) return 4;
    if (s == 1 || s == 3) return st ? 8 : 7;
    if (in_fast(a)) return 6;
    if (s == 4) return (st ? 8 + n + m : 7 + n);
    return st ? 8 : 7;
  endfunction

  // Monitor: counts clocks from accepted start to done, compares results
  bit    armed = 0, pend_v = 0;
  int    cnt = 0, reqcnt = 0;
  item_t pend;
  always @(negedge clk) if (!rst && !finished) begin
    if (pend_v) begin
      pend_v = 0;
      if (pend.in_sfr)
        check(sfr_m[pend.midx] == pend.mval, pend.req, "sfr byte", sfr_m[pend.midx], pend.mval);
      else
        check(ram[pend.midx] == pend.mval, pend.req, "ram byte", ram[pend.midx], pend.mval);
    end
    if (armed) begin
      cnt++;
      if (mem_req) reqcnt++;
      if (done) begin
        item_t it;
        it = q.pop_front();
        armed = 0;
        check(cnt == it.cyc, it.req, "cycles", cnt, it.cyc);
        check(acc_we == it.acc_we, it.req, "acc_we", acc_we, it.acc_we);
        check(psw_we == it.psw_we, it.req, "psw_we", psw_we, it.psw_we);
        if (it.acc_we) check(acc_o == it.acc, it.req, "acc_o", acc_o, it.acc);
        if (it.psw_we) check(psw_o == it.psw, it.req, "psw_o", psw_o, it.psw);
        if (it.no_bus) check(reqcnt == 0, "R11", "bus requests", reqcnt, 0);
        if (it.chk_mem) begin pend = it; pend_v = 1; end
      end
    end else begin
      if (done) check(1'b0, "R10", "unexpected done", 1, 0);
      if (start && !busy && q.size() > 0) begin armed = 1; cnt = 0; reqcnt = 0; end
    end
  end

  task automatic run_op(input string req, input int o, input int s, input logic [15:0] a,
                        input int idx, input logic [7:0] acc, input logic [7:0] psw,
                        input int n, input int m, input bit e_accwe, input logic [7:0] e_acc,
                        input bit e_pswwe, input logic [7:0] e_psw, input bit chk_mem,
                        input bit in_sfr, input logic [7:0] mval, input bit inject);
    item_t it;
    it.req = req; it.cyc = exp_cycles(o, s, a, n, m);
    it.acc_we = e_accwe; it.acc = e_acc; it.psw_we = e_pswwe; it.psw = e_psw;
    it.chk_mem = chk_mem; it.in_sfr = in_sfr; it.midx = a[7:0]; it.mval = mval;
    it.no_bus = (s <= 1);
    q.push_back(it);
    if (s == 4 && !in_fast(a)) begin rd_left = n; wr_left = m; end
    else begin rd_left = 0; wr_left = 0; end
    @(posedge clk); #1;
    op = 3'(o); space = 3'(s); addr = a; bit_idx = 3'(idx); acc_i = acc; psw_i = psw;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject) begin
      @(posedge clk); #1;
      op = 3'd4; space = 3'd0; psw_i = 8'hFF; acc_i = 8'hFF; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL R6 watchdog act=%0h exp=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; sfr_m[i] = 8'h00; end
    ram[8'h40] = 8'h20; ram[8'h10] = 8'h01; ram[8'h41] = 8'hFF; ram[8'h11] = 8'h00;
    ram[8'h50] = 8'h04; ram[8'h34] = 8'h00; ram[8'h35] = 8'hF0; ram[8'h36] = 8'h0F;
    sfr_m[8'h05] = 8'h80; sfr_m[8'h06] = 8'h55;
    rst = 1'b1; start = 1'b0; op = '0; space = '0; addr = '0; bit_idx = '0;
    acc_i = '0; psw_i = '0; mem_wait = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R6", "reset busy/done", {busy, done}, 0);
    check(!mem_req && !acc_we && !psw_we, "R11", "reset outputs", {mem_req, acc_we, psw_we}, 0);

    //      req   op sp addr      idx acc    psw    n  m  accwe acc    pswwe psw  mem sfr mval  inj
    run_op("R1", 0, 0, 16'hFE00, 3, 8'h08, 8'h00, 0, 0, 0, 8'h00, 1, 8'h01, 0, 0, 8'h00, 0);
    run_op("R3", 1, 0, 16'hFE00, 7, 8'h12, 8'h01, 0, 0, 1, 8'h92, 0, 8'h00, 0, 0, 8'h00, 0);
    run_op("R2", 2, 0, 16'hFE00, 0, 8'h00, 8'h41, 0, 0, 0, 8'h00, 1, 8'h40, 0, 0, 8'h00, 0);
    run_op("R7", 3, 1, 16'h0000, 4, 8'h00, 8'h50, 0, 0, 0, 8'h00, 1, 8'h51, 0, 0, 8'h00, 0);
    run_op("R5", 1, 1, 16'h0000, 6, 8'h00, 8'h01, 0, 0, 0, 8'h00, 1, 8'h41, 0, 0, 8'h00, 0);
    run_op("R2", 4, 1, 16'h0000, 0, 8'h00, 8'h01, 0, 0, 0, 8'h00, 1, 8'h00, 0, 0, 8'h00, 0);
    run_op("R8", 0, 2, 16'hFE40, 5, 8'h00, 8'h00, 0, 0, 0, 8'h00, 1, 8'h01, 0, 0, 8'h00, 0);
    run_op("R8", 4, 2, 16'hFE10, 0, 8'h00, 8'h01, 0, 0, 0, 8'h00, 1, 8'h00, 0, 0, 8'h00, 0);
    run_op("R4", 1, 2, 16'hFE41, 2, 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 8'hFB, 0);
    run_op("R8", 1, 2, 16'hFE11, 1, 8'h00, 8'h01, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 8'h02, 0);
    run_op("R7", 2, 3, 16'hFF05, 7, 8'h00, 8'h01, 0, 0, 0, 8'h00, 1, 8'h01, 0, 0, 8'h00, 0);
    run_op("R11", 1, 3, 16'hFF06, 0, 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 8'h54, 0);
    run_op("R9", 3, 4, 16'hFE50, 2, 8'h00, 8'h00, 0, 0, 0, 8'h00, 1, 8'h01, 0, 0, 8'h00, 0);
    run_op("R9", 0, 4, 16'h1234, 0, 8'h00, 8'h01, 3, 0, 0, 8'h00, 1, 8'h00, 0, 0, 8'h00, 0);
    run_op("R9", 1, 4, 16'h1235, 0, 8'h00, 8'h01, 2, 1, 0, 8'h00, 0, 8'h00, 1, 0, 8'hF1, 0);
    run_op("R4", 1, 4, 16'h1236, 7, 8'h00, 8'h01, 0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 8'h8F, 0);
    run_op("R10", 3, 1, 16'h0000, 2, 8'h00, 8'h04, 0, 0, 0, 8'h00, 1, 8'h05, 0, 0, 8'h00, 1);
    check(!busy, "R10", "busy after injected start", busy, 0);

    // Invalid operation code is not accepted (R10)
    @(posedge clk); #1;
    op = 3'd6; space = 3'd0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(!busy, "R10", "busy after invalid op", busy, 0);
    @(posedge clk); #1;
    op = 3'd0; space = 3'd7; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(!busy, "R10", "busy after invalid space", busy, 0);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6", "pending results", q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule